// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block creates 4-bit allocation tags and places them in 64-bit pointers. It supports two operations. A generate operation draws a pseudo-random step count from a 16-bit shift-register seed. It then walks forward from a stored start tag, skipping every tag that an exclusion mask forbids. The produced tag becomes the next start tag, and the shifted seed is stored back.

An add-with-tag operation adds a signed 64-bit offset to a pointer. It moves the pointer's existing tag forward by a caller-supplied number of allowed positions. It leaves the stored state alone.

Requests use a valid/ready handshake. Tag stepping tests one candidate per clock. A one-cycle completion pulse marks the result. Software can reload the seed and start tag through a write port at any time.

Top module: `rand_tag_unit`

## Requirements
- R1: For a generate, the exclusion mask is `req_operand_i[15:0] | excl_ctrl_i`. Bit n set forbids tag n. When at least one tag is allowed, the produced tag is never a forbidden one.
- R2: When the applicable exclusion mask is 16'hFFFF, the produced tag is 0, and the request completes one cycle after acceptance.
- R3: A generate takes its step count from four shift steps of the seed. Each step computes fb = s[5]^s[3]^s[2]^s[0] and sets s = {fb, s[15:1]}. The fb of step i (i = 0..3) is bit i of the step count.
- R4: With a step count of 0, the walk tests the start tag first. It then moves forward modulo 16 until it finds an allowed tag.
- R5: With a step count of k > 0, the walk does the following k times: move forward by one modulo 16, then keep moving while the tag is forbidden.
- R6: When a generate completes, `start_tag_o` becomes the produced tag and `seed_o` becomes the seed after the four shift steps.
- R7: When `rand_mode_i` is 1 and the stored seed is 0, a generate uses seed 1 in its place. When `rand_mode_i` is 0, a zero seed is used as is: it gives step count 0 and stays 0.
- R8: Add-with-tag (`req_op_i` = 1) returns `req_ptr_i + req_operand_i` (64-bit, two's complement). Its tag is the R4/R5 walk from `req_ptr_i[59:56]` by `req_tag_ofs_i`. This walk uses `excl_ctrl_i` alone as the mask, so `req_operand_i[15:0]` has no effect on the mask. The seed and start tag are left unchanged.
- R9: The tag occupies result bits [59:56]. All other result bits equal the base value: the pointer for a generate, the sum for add-with-tag.
- R10: `req_ready_o` is 1 when the block is idle and 0 from the cycle after acceptance until completion. If a request tests n candidates, `done_o` is high for exactly one cycle, n cycles after the accepting edge, and `result_o` is valid in that cycle.
- R11: A state write (`st_wr_i`) loads `seed_o` and `start_tag_o` at the next edge. If it coincides with the completion edge of a generate, the write wins.
- R12: Every request completes within 256 cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears seed and start tag to 0 |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_op_i | input | 1 | 0 = generate, 1 = add-with-tag |
| req_ptr_i | input | 64 | Source pointer |
| req_operand_i | input | 64 | Generate: low 16 bits extra exclusion; add: signed offset |
| req_tag_ofs_i | input | 4 | Tag step count for add-with-tag |
| excl_ctrl_i | input | 16 | Control exclusion mask |
| rand_mode_i | input | 1 | Replace a zero seed with 1 before generating |
| st_wr_i | input | 1 | Reload stored state |
| st_seed_i | input | 16 | Seed value to load |
| st_tag_i | input | 4 | Start tag value to load |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Tagged pointer, valid with done_o |
| seed_o | output | 16 | Stored seed |
| start_tag_o | output | 4 | Stored start tag |

## Verification
Two functions can land on the same edge: the commit of a finished generate and a software reload of the seed and start tag. The bench computes how many candidates a given request walks through, so it knows the exact completion edge. It raises the reload write in the cycle just before that edge. The behavioural model then expects the written values, not the generated ones, in `seed_o` and `start_tag_o`. It still expects the generated tag in `result_o` during the done cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic {
    OP_GEN  = 1'b0,
    OP_ADDG = 1'b1
  } rtg_op_e;
endpackage

// File: rtl/rtg_lfsr4.sv
module rtg_lfsr4 #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [STEPS-1:0]  bits_o
);
  logic [SEED_W-1:0] chain [STEPS+1];

  assign chain[0] = seed_i;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic fb;
    assign fb          = chain[i][5] ^ chain[i][3] ^ chain[i][2] ^ chain[i][0];
    assign chain[i+1]  = {fb, chain[i][SEED_W-1:1]};
    assign bits_o[i]   = fb;
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/rtg_walker.sv
module rtg_walker #(
  parameter int TAG_W = 4,
  localparam int NTAGS = 1 << TAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TAG_W-1:0] start_tag_i,
  input  logic [TAG_W-1:0] steps_i,
  input  logic [NTAGS-1:0] mask_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [TAG_W-1:0] fin_tag_o,
  output logic             done_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  logic [TAG_W-1:0] cur_q, rem_q, tag_q;
  logic [NTAGS-1:0] mask_q;
  logic             busy_q, done_q;
  logic             all_excl, cand_ok;

  assign all_excl  = &mask_q;
  assign cand_ok   = !mask_q[cur_q];
  assign fin_o     = busy_q && (all_excl || (cand_ok && rem_q == ONE));
  assign fin_tag_o = all_excl ? '0 : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      rem_q  <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      done_q <= fin_o;
      if (fin_o) tag_q <= fin_tag_o;
      if (load_i) begin
        // zero steps: test start itself; else first candidate is start+1
        cur_q  <= (steps_i == '0) ? start_tag_i : start_tag_i + ONE;
        rem_q  <= (steps_i == '0) ? ONE : steps_i;
        mask_q <= mask_i;
        busy_q <= 1'b1;
      end else if (fin_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cur_q <= cur_q + ONE;
        if (cand_ok) rem_q <= rem_q - ONE;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tag_o  = tag_q;

  // busy-cycle counter for the latency bound check
  logic [2*TAG_W:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt_q <= '0;
    else if (load_i)  busy_cnt_q <= '0;
    else if (busy_q)  busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  p_tag_allowed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(&mask_q)) |-> !mask_q[tag_q]);

  p_all_excl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && (&mask_q)) |-> (tag_q == '0));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_bounded_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (busy_cnt_q < (NTAGS * NTAGS)));
endmodule

// File: rtl/rtg_state.sv
module rtg_state #(
  parameter int SEED_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEED_W-1:0] wr_seed_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              commit_i,
  input  logic [SEED_W-1:0] commit_seed_i,
  input  logic [TAG_W-1:0]  commit_tag_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [TAG_W-1:0]  tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_o <= '0;
      tag_o  <= '0;
    end else if (wr_i) begin
      seed_o <= wr_seed_i;
      tag_o  <= wr_tag_i;
    end else if (commit_i) begin
      seed_o <= commit_seed_i;
      tag_o  <= commit_tag_i;
    end
  end

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (seed_o == $past(wr_seed_i)) && (tag_o == $past(wr_tag_i)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !commit_i) |=> ($stable(seed_o) && $stable(tag_o)));
endmodule

// File: rtl/rand_tag_unit.sv
module rand_tag_unit
  import rtg_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int SEED_W  = 16,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 56,
  localparam int NTAGS  = 1 << TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_op_i,
  input  logic [PTR_W-1:0]  req_ptr_i,
  input  logic [PTR_W-1:0]  req_operand_i,
  input  logic [TAG_W-1:0]  req_tag_ofs_i,
  input  logic [NTAGS-1:0]  excl_ctrl_i,
  input  logic              rand_mode_i,
  input  logic              st_wr_i,
  input  logic [SEED_W-1:0] st_seed_i,
  input  logic [TAG_W-1:0]  st_tag_i,
  output logic              done_o,
  output logic [PTR_W-1:0]  result_o,
  output logic [SEED_W-1:0] seed_o,
  output logic [TAG_W-1:0]  start_tag_o
);
  rtg_op_e           op_req, op_q;
  logic              accept, busy, fin, commit, rand_q;
  logic [SEED_W-1:0] seed_eff, seed_shift, seed_nxt_q;
  logic [TAG_W-1:0]  lfsr_bits, walk_start, walk_steps, fin_tag, tag_out;
  logic [NTAGS-1:0]  walk_mask;
  logic [PTR_W-1:0]  base_q;

  assign op_req      = rtg_op_e'(req_op_i);
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  // zero seed in random mode is forced to 1
  assign seed_eff = (rand_mode_i && seed_o == '0) ? SEED_W'(1) : seed_o;

  rtg_lfsr4 #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_lfsr (
    .seed_i (seed_eff),
    .seed_o (seed_shift),
    .bits_o (lfsr_bits)
  );

  always_comb begin
    if (op_req == OP_GEN) begin
      walk_start = start_tag_o;
      walk_steps = lfsr_bits;
      walk_mask  = req_operand_i[NTAGS-1:0] | excl_ctrl_i;
    end else begin
      walk_start = req_ptr_i[TAG_LSB +: TAG_W];
      walk_steps = req_tag_ofs_i;
      walk_mask  = excl_ctrl_i;
    end
  end

  rtg_walker #(.TAG_W(TAG_W)) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .start_tag_i (walk_start),
    .steps_i     (walk_steps),
    .mask_i      (walk_mask),
    .busy_o      (busy),
    .fin_o       (fin),
    .fin_tag_o   (fin_tag),
    .done_o      (done_o),
    .tag_o       (tag_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_GEN;
      base_q     <= '0;
      seed_nxt_q <= '0;
      rand_q     <= 1'b0;
    end else if (accept) begin
      op_q       <= op_req;
      base_q     <= (op_req == OP_GEN) ? req_ptr_i : req_ptr_i + req_operand_i;
      seed_nxt_q <= seed_shift;
      rand_q     <= rand_mode_i;
    end
  end

  assign commit = fin && (op_q == OP_GEN);

  rtg_state #(.SEED_W(SEED_W), .TAG_W(TAG_W)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (st_wr_i),
    .wr_seed_i     (st_seed_i),
    .wr_tag_i      (st_tag_i),
    .commit_i      (commit),
    .commit_seed_i (seed_nxt_q),
    .commit_tag_i  (fin_tag),
    .seed_o        (seed_o),
    .tag_o         (start_tag_o)
  );

  always_comb begin
    result_o = base_q;
    result_o[TAG_LSB +: TAG_W] = tag_out;
  end

  p_busy_after_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  p_rand_seed_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && rand_q) |-> (seed_nxt_q != '0));

  p_commit_loads_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !st_wr_i) |=> (start_tag_o == tag_out));
endmodule

// File: tb/rand_tag_unit_bench.sv
module rand_tag_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_op_i = 1'b0;
  logic [63:0] req_ptr_i = '0;
  logic [63:0] req_operand_i = '0;
  logic [3:0]  req_tag_ofs_i = '0;
  logic [15:0] excl_ctrl_i = '0;
  logic        rand_mode_i = 1'b0;
  logic        st_wr_i = 1'b0;
  logic [15:0] st_seed_i = '0;
  logic [3:0]  st_tag_i = '0;
  logic        done_o;
  logic [63:0] result_o;
  logic [15:0] seed_o;
  logic [3:0]  start_tag_o;

  int compared = 0;
  int mismatched = 0;
  int m_seed = 0;
  int m_tag = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rand_tag_unit u_rand_tag_unit (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural walk: returns tag and number of candidates tested
  task automatic model_walk(input int start, input int ofs, input int mask,
                            output int tag, output int n);
    int t;
    t = start;
    if (mask == 16'hFFFF) begin
      tag = 0; n = 1; return;
    end
    if (ofs == 0) begin
      n = 1;
      while (mask[t]) begin t = (t + 1) % 16; n++; end
    end else begin
      n = 0;
      for (int j = 0; j < ofs; j++) begin
        do begin t = (t + 1) % 16; n++; end while (mask[t]);
      end
    end
    tag = t;
  endtask

  task automatic model_lfsr(input int s_in, output int s_out, output int ofs);
    int s, fb;
    s = s_in; ofs = 0;
    for (int i = 0; i < 4; i++) begin
      fb = ((s >> 5) ^ (s >> 3) ^ (s >> 2) ^ s) & 1;
      s = (fb << 15) | (s >> 1);
      ofs |= fb << i;
    end
    s_out = s;
  endtask

  task automatic write_state(input int seed, input int tag);
    st_wr_i = 1'b1; st_seed_i = 16'(seed); st_tag_i = 4'(tag);
    @(negedge clk_i);
    st_wr_i = 1'b0;
    m_seed = seed; m_tag = tag;
    check("R11 seed load", 64'(seed_o), 64'(seed));
    check("R11 tag load", 64'(start_tag_o), 64'(tag));
  endtask

  task automatic do_req(input string req, input bit op, input logic [63:0] ptr,
                        input logic [63:0] operand, input int tofs, input int ctrl,
                        input bit rnd, input bit wr_end, input int wr_seed, input int wr_tag);
    int s, s_new, ofs, mask, start, tag, n, nseed, ntag;
    logic [63:0] exp_res;
    s_new = m_seed;
    if (!op) begin
      s = m_seed;
      if (rnd && s == 0) s = 1;
      model_lfsr(s, s_new, ofs);
      mask = int'(operand[15:0]) | ctrl;
      start = m_tag;
      exp_res = ptr;
    end else begin
      mask = ctrl;
      start = int'(ptr[59:56]);
      ofs = tofs;
      exp_res = ptr + operand;
    end
    model_walk(start, ofs, mask, tag, n);
    exp_res[59:56] = 4'(tag);
    if (wr_end) begin nseed = wr_seed; ntag = wr_tag; end
    else if (!op) begin nseed = s_new; ntag = tag; end
    else begin nseed = m_seed; ntag = m_tag; end

    check({req, " R10 ready idle"}, 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_op_i = op; req_ptr_i = ptr; req_operand_i = operand;
    req_tag_ofs_i = 4'(tofs); excl_ctrl_i = 16'(ctrl); rand_mode_i = rnd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (wr_end && k == n - 1) begin
        st_wr_i = 1'b1; st_seed_i = 16'(wr_seed); st_tag_i = 4'(wr_tag);
      end
      check({req, " R10 busy ready"}, 64'(req_ready_o), 64'd0);
      check({req, " R10 no early done"}, 64'(done_o), 64'd0);
      check({req, " R6 seed held"}, 64'(seed_o), 64'(m_seed));
      check({req, " R6 tag held"}, 64'(start_tag_o), 64'(m_tag));
      @(negedge clk_i);
      st_wr_i = 1'b0;
    end
    check({req, " R10 done"}, 64'(done_o), 64'd1);
    check({req, " R10 ready back"}, 64'(req_ready_o), 64'd1);
    check({req, " R9 result"}, result_o, exp_res);
    check({req, " R6 seed"}, 64'(seed_o), 64'(nseed));
    check({req, " R6 start tag"}, 64'(start_tag_o), 64'(ntag));
    m_seed = nseed; m_tag = ntag;
    @(negedge clk_i);
    check({req, " R10 done pulse"}, 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD) @(posedge clk_i);
    repeat (200000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 reset seed", 64'(seed_o), 64'd0);
    check("R11 reset tag", 64'(start_tag_o), 64'd0);
    check("R10 reset done", 64'(done_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 reset ready", 64'(req_ready_o), 64'd1);

    // R7: zero seed without random mode -> offset 0, seed stays 0
    do_req("R7 zero seed plain", 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0, 0, 16'h0001, 1'b0, 1'b0, 0, 0);
    // R7: zero seed in random mode -> seed 1 used
    do_req("R7 zero seed rand", 1'b0, 64'h0F00_0000_0000_1000, 64'h0, 0, 16'h0000, 1'b1, 1'b0, 0, 0);

    write_state(16'hACE1, 3);
    // R3 R5: plain generates, several seeds
    do_req("R3 gen no mask", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 0, 1'b0, 1'b0, 0, 0);
    do_req("R5 gen seq", 1'b0, 64'h1234_0000_0000_0010, 64'h0, 0, 0, 1'b0, 1'b0, 0, 0);
    do_req("R5 gen seq2", 1'b0, 64'h00A0_0000_0000_0020, 64'h0, 0, 0, 1'b0, 1'b0, 0, 0);
    // R1: operand mask ORed with control mask
    do_req("R1 gen mixed mask", 1'b0, 64'h5555_5555_5555_5555, 64'hFFFF_0000_0000_00F0, 0, 16'h0F0F, 1'b0, 1'b0, 0, 0);
    // R1: only tag 9 allowed -> long walk
    do_req("R1 gen one allowed", 1'b0, 64'h0, 64'h0000_0000_0000_FD00, 0, 16'h00FF, 1'b0, 1'b0, 0, 0);
    // R2: all excluded
    do_req("R2 gen all excl", 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_FF00, 0, 16'h00FF, 1'b0, 1'b0, 0, 0);
    // R4: seed chosen so step count is 0 (seed 0 plain), start tag excluded
    write_state(0, 14);
    do_req("R4 gen offset0 skip", 1'b0, 64'h0, 64'h0000_0000_0000_4000, 0, 16'h8000, 1'b0, 1'b0, 0, 0);

    // R8: add with tag
    do_req("R8 add pos", 1'b1, 64'h0300_0000_0000_1000, 64'h0000_0000_0000_0040, 2, 16'h0010, 1'b0, 1'b0, 0, 0);
    do_req("R8 add neg", 1'b1, 64'h0F00_0000_0000_0010, 64'hFFFF_FFFF_FFFF_FFE0, 1, 16'h0000, 1'b0, 1'b0, 0, 0);
    do_req("R8 add operand mask ignored", 1'b1, 64'h0500_0000_0000_0000, 64'h0000_0000_0000_FFFF, 0, 16'h0000, 1'b0, 1'b0, 0, 0);
    do_req("R4 add ofs0 excluded", 1'b1, 64'h0500_0000_0000_0000, 64'h0, 0, 16'h0060, 1'b0, 1'b0, 0, 0);
    do_req("R5 add wrap", 1'b1, 64'h0E00_0000_0000_0008, 64'h8, 15, 16'h5555, 1'b0, 1'b0, 0, 0);
    do_req("R2 add all excl", 1'b1, 64'h0700_0000_0000_0000, 64'h1, 3, 16'hFFFF, 1'b0, 1'b0, 0, 0);

    // R11: write coinciding with generate commit
    write_state(16'h1357, 6);
    do_req("R11 write vs commit", 1'b0, 64'h0000_1111_2222_3333, 64'h0, 0, 16'h0300, 1'b0, 1'b1, 16'hBEEF, 11);
    do_req("R12 gen after write", 1'b0, 64'h0, 64'h0000_0000_0000_7FFE, 0, 0, 1'b1, 1'b0, 0, 0);
    for (int i = 0; i < 6; i++)
      do_req("R3 gen run", 1'b0, 64'(i) << 40, 64'(16'h0101 << (i % 8)), 0, 16'h0020, 1'b1, 1'b0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule